// File: doc/BRIEF.md
# Three-Phase Luma Sub-Pixel Interpolation Filter Bank

This block takes a window of eight neighbouring samples and, in one pass, produces the three fractional-position interpolations used for luma motion compensation: the quarter, half and three-quarter positions. The samples can be integer pixels for a first filtering pass, or signed intermediate values from an earlier pass for a second pass across the other direction. The block returns all three filtered values together, each scaled down by a right shift chosen per window.

The filter bank does not use multipliers. Each sample passes through one shift-and-add network. That network builds the scaled copies of the sample that the three coefficient sets need, and each copy is built only once. The per-phase sums then draw from these shared terms. A window is accepted on any cycle that has its valid strobe set, so a new window can enter on every cycle. The three results appear together, a fixed number of cycles later, with their own valid pulse.

For a first pass over pixels of bit depth D, the caller sets the shift to D-8 and clears the signed-mode input. For a second pass over intermediates, the caller sets the shift to 6 and sets signed mode.

Top module: `subpel_fir3`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, `out_valid` is 0 and all three result outputs are 0.
- R2: Each cycle with `in_valid` high produces exactly one cycle of `out_valid` high, 3 clock cycles later. Windows accepted on consecutive cycles give results on consecutive cycles, in the same order.
- R3: `out_qtr` equals the floor of (sum over lanes t of wq[t]*s[t]) / 2^`norm_shift`. Lane t is `samples[t*IN_W +: IN_W]`, and wq for lanes 0..7 is -1, 4, -10, 58, 17, -5, 1, 0, so lane 7 has no effect on it.
- R4: `out_half` is formed the same way, with the symmetric weights -1, 4, -11, 40, 40, -11, 4, -1 for lanes 0..7.
- R5: `out_3qtr` is formed the same way, with the weights 0, 1, -5, 17, 58, -10, 4, -1 for lanes 0..7, so lane 0 has no effect on it.
- R6: With `in_signed` = 1, each lane is read as a two's-complement value. With `in_signed` = 0, each lane is read as an unsigned value in 0 .. 2^IN_W-1.
- R7: The scaling is an arithmetic right shift of the full-precision sum by `norm_shift` (0..15), so negative results round toward minus infinity.
- R8: Between valid pulses, all three result outputs keep the values of the last result.
- R9: Results are exact, with no wrap-around, for every lane value in either mode, including all lanes at their extremes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Window strobe |
| in_signed | input | 1 | 1: lanes are two's complement; 0: lanes are unsigned |
| norm_shift | input | SHIFT_W | Right shift applied to the three sums |
| samples | input | 8*IN_W | Eight lanes; lane t at bits t*IN_W upward |
| out_valid | output | 1 | Result strobe |
| out_qtr | output | IN_W+11 | Quarter-position result, signed |
| out_half | output | IN_W+11 | Half-position result, signed |
| out_3qtr | output | IN_W+11 | Three-quarter-position result, signed |

## Verification
The assertions check three things on every cycle. The result strobe must follow the input strobe by exactly three cycles. The outputs must stay frozen between strobes and be cleared by reset. Inside each sample's shift-add network, every nonzero sample weighted by the half-position coefficient must give a product of the expected sign, which catches wrap-around in the shared terms. The exact arithmetic values, the lanes that each phase ignores, the unsigned versus signed reading of lanes, and the floor behaviour of the shift can only be shown by the bench. It does this by comparing every result against a plain dot product, over random pixel windows, random signed intermediates, extreme-value windows and negative sums.

// File: rtl/subpel_pkg.sv
`timescale 1ns/1ps
package subpel_pkg;
  localparam int NTAPS       = 8;
  localparam int NPHASE      = 3;
  localparam int PIPE_DEPTH  = 3;
  // largest coefficient magnitude is 58 < 2^6, plus one sign bit
  localparam int COEF_GROWTH = 7;
  // an eight-term sum grows by at most three bits
  localparam int SUM_GROWTH  = 3;

  typedef enum int {PH_QTR = 0, PH_HALF = 1, PH_3QTR = 2} phase_e;

  // weight of lane 'tap' in the equation of phase 'ph'
  function automatic int tap_coef(input int ph, input int tap);
    int t;
    int c;
    // the three-quarter phase is the mirror image of the quarter phase
    t = (ph == PH_3QTR) ? (NTAPS - 1 - tap) : tap;
    c = 0;
    if (ph == PH_HALF) begin
      case (t)
        0, 7:    c = -1;
        1, 6:    c = 4;
        2, 5:    c = -11;
        default: c = 40;
      endcase
    end else begin
      case (t)
        0:       c = -1;
        1:       c = 4;
        2:       c = -10;
        3:       c = 58;
        4:       c = 17;
        5:       c = -5;
        6:       c = 1;
        default: c = 0;
      endcase
    end
    return c;
  endfunction
endpackage

// File: rtl/subpel_tap_net.sv
`timescale 1ns/1ps
// Shift-add network for one lane: builds each scaled copy of the sample
// once and hands the three phase equations their weighted term.
module subpel_tap_net
  import subpel_pkg::*;
#(
  parameter int EXT_W  = 17,
  parameter int PROD_W = 24,
  parameter int TAP    = 0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic signed [EXT_W-1:0]  x,
  output logic signed [PROD_W-1:0] p_qtr,
  output logic signed [PROD_W-1:0] p_half,
  output logic signed [PROD_W-1:0] p_3qtr
);
  localparam int CQ = tap_coef(PH_QTR,  TAP);
  localparam int CH = tap_coef(PH_HALF, TAP);
  localparam int CT = tap_coef(PH_3QTR, TAP);

  logic signed [PROD_W-1:0] t1, t4, t5, t10, t11, t17, t40, t58;
  logic signed [PROD_W-1:0] w_q, w_h, w_t;

  // shared term graph: 5 -> 10 -> 11, 5 -> 40, 40 + 17 + 1 -> 58
  assign t1  = {{(PROD_W-EXT_W){x[EXT_W-1]}}, x};
  assign t4  = t1 <<< 2;
  assign t5  = t4 + t1;
  assign t10 = t5 <<< 1;
  assign t11 = t10 + t1;
  assign t17 = (t1 <<< 4) + t1;
  assign t40 = t5 <<< 3;
  assign t58 = t40 + t17 + t1;

  function automatic logic signed [PROD_W-1:0] pick(
    input int c,
    input logic signed [PROD_W-1:0] a1, a4, a5, a10, a11, a17, a40, a58);
    int m;
    logic signed [PROD_W-1:0] r;
    m = (c < 0) ? -c : c;
    case (m)
      1:       r = a1;
      4:       r = a4;
      5:       r = a5;
      10:      r = a10;
      11:      r = a11;
      17:      r = a17;
      40:      r = a40;
      58:      r = a58;
      default: r = '0;
    endcase
    return (c < 0) ? -r : r;
  endfunction

  always_comb begin
    w_q = pick(CQ, t1, t4, t5, t10, t11, t17, t40, t58);
    w_h = pick(CH, t1, t4, t5, t10, t11, t17, t40, t58);
    w_t = pick(CT, t1, t4, t5, t10, t11, t17, t40, t58);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_qtr  <= '0;
      p_half <= '0;
      p_3qtr <= '0;
    end else if (en) begin
      p_qtr  <= w_q;
      p_half <= w_h;
      p_3qtr <= w_t;
    end
  end

  // R9: a positive sample must yield a product carrying the coefficient's sign
  assert_pos_sign_R9: assert property (@(posedge clk) disable iff (rst)
    (en && (x > 0)) |=> ((CH > 0) ? (p_half > 0) : (p_half < 0)));

  // R9: a negative sample must yield a product of the opposite sign
  assert_neg_sign_R9: assert property (@(posedge clk) disable iff (rst)
    (en && (x < 0)) |=> ((CH > 0) ? (p_half < 0) : (p_half > 0)));
endmodule

// File: rtl/subpel_phase_sum.sv
`timescale 1ns/1ps
// Balanced adder tree over the eight weighted lanes of one phase,
// followed by the normalising arithmetic shift.
module subpel_phase_sum
  import subpel_pkg::*;
#(
  parameter int PROD_W  = 24,
  parameter int ACC_W   = 27,
  parameter int SHIFT_W = 4
) (
  input  logic signed [PROD_W-1:0] terms [NTAPS],
  input  logic [SHIFT_W-1:0]       shift,
  output logic signed [ACC_W-1:0]  result
);
  logic signed [ACC_W-1:0] lvl0 [NTAPS];
  logic signed [ACC_W-1:0] lvl1 [NTAPS/2];
  logic signed [ACC_W-1:0] lvl2 [NTAPS/4];
  logic signed [ACC_W-1:0] total;

  for (genvar g = 0; g < NTAPS; g++) begin : g_ext
    assign lvl0[g] = {{(ACC_W-PROD_W){terms[g][PROD_W-1]}}, terms[g]};
  end
  for (genvar g = 0; g < NTAPS/2; g++) begin : g_l1
    assign lvl1[g] = lvl0[2*g] + lvl0[2*g+1];
  end
  for (genvar g = 0; g < NTAPS/4; g++) begin : g_l2
    assign lvl2[g] = lvl1[2*g] + lvl1[2*g+1];
  end
  assign total  = lvl2[0] + lvl2[1];
  assign result = total >>> shift;
endmodule

// File: rtl/subpel_fir3.sv
`timescale 1ns/1ps
module subpel_fir3
  import subpel_pkg::*;
#(
  parameter int IN_W    = 16,
  parameter int SHIFT_W = 4
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      in_valid,
  input  logic                                      in_signed,
  input  logic [SHIFT_W-1:0]                        norm_shift,
  input  logic [NTAPS*IN_W-1:0]                     samples,
  output logic                                      out_valid,
  output logic signed [IN_W+COEF_GROWTH+SUM_GROWTH:0] out_qtr,
  output logic signed [IN_W+COEF_GROWTH+SUM_GROWTH:0] out_half,
  output logic signed [IN_W+COEF_GROWTH+SUM_GROWTH:0] out_3qtr
);
  localparam int EXT_W  = IN_W + 1;
  localparam int PROD_W = EXT_W + COEF_GROWTH;
  localparam int ACC_W  = PROD_W + SUM_GROWTH;

  logic [PIPE_DEPTH-1:0]    vld_q;
  logic signed [EXT_W-1:0]  win_q [NTAPS];
  logic [SHIFT_W-1:0]       sh1_q, sh2_q;
  logic signed [PROD_W-1:0] prod_q [NTAPS];
  logic signed [PROD_W-1:0] prod_h [NTAPS];
  logic signed [PROD_W-1:0] prod_t [NTAPS];
  logic signed [ACC_W-1:0]  res_q, res_h, res_t;

  // stage 1: capture window, widen lanes by the mode bit
  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= {vld_q[PIPE_DEPTH-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      for (int t = 0; t < NTAPS; t++) begin
        win_q[t] <= {in_signed & samples[t*IN_W+IN_W-1], samples[t*IN_W +: IN_W]};
      end
      sh1_q <= norm_shift;
    end
  end

  // stage 2: one shared shift-add network per lane
  for (genvar g = 0; g < NTAPS; g++) begin : g_tap
    subpel_tap_net #(.EXT_W(EXT_W), .PROD_W(PROD_W), .TAP(g)) u_net (
      .clk    (clk),
      .rst    (rst),
      .en     (vld_q[0]),
      .x      (win_q[g]),
      .p_qtr  (prod_q[g]),
      .p_half (prod_h[g]),
      .p_3qtr (prod_t[g])
    );
  end

  always_ff @(posedge clk) begin
    if (vld_q[0]) sh2_q <= sh1_q;
  end

  // stage 3: per-phase sums and normalisation
  subpel_phase_sum #(.PROD_W(PROD_W), .ACC_W(ACC_W), .SHIFT_W(SHIFT_W)) u_sum_q (
    .terms(prod_q), .shift(sh2_q), .result(res_q));
  subpel_phase_sum #(.PROD_W(PROD_W), .ACC_W(ACC_W), .SHIFT_W(SHIFT_W)) u_sum_h (
    .terms(prod_h), .shift(sh2_q), .result(res_h));
  subpel_phase_sum #(.PROD_W(PROD_W), .ACC_W(ACC_W), .SHIFT_W(SHIFT_W)) u_sum_t (
    .terms(prod_t), .shift(sh2_q), .result(res_t));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_qtr  <= '0;
      out_half <= '0;
      out_3qtr <= '0;
    end else if (vld_q[1]) begin
      out_qtr  <= res_q;
      out_half <= res_h;
      out_3qtr <= res_t;
    end
  end

  assign out_valid = vld_q[PIPE_DEPTH-1];

  // cycles since reset, saturating, so the latency check never looks into reset
  logic [1:0] since_rst_q;
  always_ff @(posedge clk) begin
    if (rst)                     since_rst_q <= '0;
    else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
  end

  assert_fixed_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (since_rst_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_qtr == '0 && out_half == '0 && out_3qtr == '0));

  assert_hold_between_R8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_qtr) && $stable(out_half) && $stable(out_3qtr)));
endmodule

// File: tb/subpel_fir3_test.sv
`timescale 1ns/1ps
module subpel_fir3_test;
  localparam int IN_W    = 16;
  localparam int SHIFT_W = 4;
  localparam int OUT_W   = IN_W + 11;
  localparam int LANES   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_signed = 1'b0;
  logic [SHIFT_W-1:0] norm_shift = '0;
  logic [LANES*IN_W-1:0] samples = '0;
  logic out_valid;
  logic signed [OUT_W-1:0] out_qtr, out_half, out_3qtr;

  int errors = 0;
  int checks = 0;

  longint exp_q[$];
  longint exp_h[$];
  longint exp_t[$];
  string  scen_q[$];
  longint last_q = 0, last_h = 0, last_t = 0;

  always #10 clk = ~clk;

  subpel_fir3 #(.IN_W(IN_W), .SHIFT_W(SHIFT_W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_signed(in_signed),
    .norm_shift(norm_shift), .samples(samples), .out_valid(out_valid),
    .out_qtr(out_qtr), .out_half(out_half), .out_3qtr(out_3qtr));

  // weights taken from requirements R3, R4, R5
  function automatic longint weight(int ph, int t);
    int wq [8] = '{-1, 4, -10, 58, 17, -5, 1, 0};
    int wh [8] = '{-1, 4, -11, 40, 40, -11, 4, -1};
    int wt [8] = '{0, 1, -5, 17, 58, -10, 4, -1};
    if (ph == 0) return longint'(wq[t]);
    if (ph == 1) return longint'(wh[t]);
    return longint'(wt[t]);
  endfunction

  // lane reading per R6
  function automatic longint lane_val(logic [LANES*IN_W-1:0] s, int t, bit sgn);
    logic [IN_W-1:0] v;
    v = s[t*IN_W +: IN_W];
    if (sgn) return longint'($signed(v));
    return longint'({48'd0, v});
  endfunction

  // dot product then floor shift per R7
  function automatic longint model(int ph, logic [LANES*IN_W-1:0] s, bit sgn, int sh);
    longint acc;
    acc = 0;
    for (int t = 0; t < LANES; t++) acc += weight(ph, t) * lane_val(s, t, sgn);
    return acc >>> sh;
  endfunction

  function automatic logic [LANES*IN_W-1:0] rnd_vec(int bits, bit sgn);
    logic [LANES*IN_W-1:0] r;
    logic [31:0] mask;
    r = '0;
    mask = (bits >= 32) ? 32'hFFFF_FFFF : ((32'd1 << bits) - 32'd1);
    for (int t = 0; t < LANES; t++) begin
      logic [31:0] u;
      logic [IN_W-1:0] v;
      u = $urandom;
      v = IN_W'(u & mask);
      if (sgn && u[bits-1]) v = v | ~IN_W'(mask);
      r[t*IN_W +: IN_W] = v;
    end
    return r;
  endfunction

  function automatic logic [LANES*IN_W-1:0] put_lane(logic [LANES*IN_W-1:0] s, int t,
                                                     logic [IN_W-1:0] v);
    logic [LANES*IN_W-1:0] r;
    r = s;
    r[t*IN_W +: IN_W] = v;
    return r;
  endfunction

  task automatic check_val(string req, string scen, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s): actual=%0d expected=%0d", req, scen, act, exp);
    end
  endtask

  task automatic expect_add(logic [LANES*IN_W-1:0] s, bit sgn, int sh, string scen);
    exp_q.push_back(model(0, s, sgn, sh));
    exp_h.push_back(model(1, s, sgn, sh));
    exp_t.push_back(model(2, s, sgn, sh));
    scen_q.push_back(scen);
  endtask

  // driver: called at a falling edge, holds the window for one cycle
  task automatic push(logic [LANES*IN_W-1:0] s, bit sgn, int sh, string scen);
    samples    = s;
    in_signed  = sgn;
    norm_shift = SHIFT_W'(sh);
    in_valid   = 1'b1;
    expect_add(s, sgn, sh, scen);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops the scoreboard whenever a result is presented
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (scen_q.size() == 0) begin
          check_val("R2", "unexpected result", 1, 0);
        end else begin
          string sc;
          longint eq, eh, et;
          sc = scen_q.pop_front();
          eq = exp_q.pop_front();
          eh = exp_h.pop_front();
          et = exp_t.pop_front();
          check_val("R3", sc, longint'(out_qtr),  eq);
          check_val("R4", sc, longint'(out_half), eh);
          check_val("R5", sc, longint'(out_3qtr), et);
          last_q = eq;
          last_h = eh;
          last_t = et;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [LANES*IN_W-1:0] v;
    int lat;
    int pulses;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: cleared state right after reset
    check_val("R1", "reset valid", longint'(out_valid), 0);
    check_val("R1", "reset qtr",   longint'(out_qtr),   0);
    check_val("R1", "reset half",  longint'(out_half),  0);
    check_val("R1", "reset 3qtr",  longint'(out_3qtr),  0);

    // R2: single strobe, result exactly three cycles later, one pulse
    v = rnd_vec(8, 1'b0);
    samples = v; in_signed = 1'b0; norm_shift = '0; in_valid = 1'b1;
    expect_add(v, 1'b0, 0, "R2 single");
    lat = 0;
    pulses = 0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      if (out_valid) begin
        pulses++;
        if (lat == 0) lat = k;
      end
    end
    check_val("R2", "latency", lat, 3);
    check_val("R2", "pulse count", pulses, 1);

    // 8-bit pixels, first pass, back-to-back (R2 streaming, R6 unsigned)
    for (int i = 0; i < 12; i++) push(rnd_vec(8, 1'b0), 1'b0, 0, "R6 8-bit stream");
    idle(2);
    // 10-bit pixels, shift 2 (R7)
    for (int i = 0; i < 10; i++) push(rnd_vec(10, 1'b0), 1'b0, 2, "R7 10-bit shift2");
    idle(1);
    // signed intermediates, shift 6 (R6 signed)
    for (int i = 0; i < 12; i++) push(rnd_vec(16, 1'b1), 1'b1, 6, "R6 signed pass2");

    // R3: lane 7 ignored by quarter phase; R5: lane 0 ignored by 3qtr phase
    v = rnd_vec(8, 1'b0);
    push(put_lane(v, 7, 16'd0),   1'b0, 0, "R3 lane7 zero");
    push(put_lane(v, 7, 16'd255), 1'b0, 0, "R3 lane7 max");
    push(put_lane(v, 0, 16'd0),   1'b0, 0, "R5 lane0 zero");
    push(put_lane(v, 0, 16'd255), 1'b0, 0, "R5 lane0 max");
    idle(3);

    // R9: extreme windows, no shift
    push({LANES{16'hFFFF}}, 1'b0, 0, "R9 all max unsigned");
    v = '0;
    v = put_lane(v, 1, 16'hFFFF); v = put_lane(v, 3, 16'hFFFF);
    v = put_lane(v, 4, 16'hFFFF); v = put_lane(v, 6, 16'hFFFF);
    push(v, 1'b0, 0, "R9 half peak positive");
    v = {LANES{16'h7FFF}};
    v = put_lane(v, 1, 16'h8000); v = put_lane(v, 3, 16'h8000);
    v = put_lane(v, 4, 16'h8000); v = put_lane(v, 6, 16'h8000);
    push(v, 1'b1, 0, "R9 half peak negative");
    v = {LANES{16'h8000}};
    v = put_lane(v, 3, 16'h7FFF); v = put_lane(v, 4, 16'h7FFF);
    push(v, 1'b1, 0, "R9 signed mix");
    push({LANES{16'h8000}}, 1'b0, 0, "R6 top bit unsigned");

    // R7: negative sums floor toward minus infinity
    push(put_lane('0, 3, 16'hFFFF), 1'b1, 3, "R7 floor lane3");
    push(put_lane('0, 4, 16'hFFFF), 1'b1, 5, "R7 floor lane4");
    push({LANES{16'hFFFF}}, 1'b1, 15, "R7 max shift");
    idle(1);

    wait (scen_q.size() == 0);
    idle(3);
    // R8: outputs keep the last result while no strobe arrives
    for (int k = 0; k < 3; k++) begin
      check_val("R8", "hold valid", longint'(out_valid), 0);
      check_val("R8", "hold qtr",   longint'(out_qtr),   last_q);
      check_val("R8", "hold half",  longint'(out_half),  last_h);
      check_val("R8", "hold 3qtr",  longint'(out_3qtr),  last_t);
      @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule